// File: doc/BRIEF.md
# Per-Port Strap and Management Register Arbiter

This block owns the control and mode register bits of a multi-port Ethernet transceiver. For each port it decides whether a bit's value comes from the global strap pins, from the port's own signal-detect and tristate pins, or from a management write. A management-lock input sets the policy. When the lock is high, the pins drive the bits on every clock and writes have no effect. When the lock is low, the pins are captured as defaults only while the port is in reset, and management writes take over after that.

The block also has these functions. It restarts auto-negotiation on a strap edge. It forces fibre operation from signal detect and picks the duplex pin that matches the medium. It forces scrambler bypass on fibre ports. It merges the reset and power-down pins with their register bits and stretches the resulting reset. It forms each port's management address. It raises an active-low status-change interrupt that software clears with an ordered two-register read. Register access uses a parallel strobe interface in place of a serial management framer. Read data appears on the cycle after the read strobe.

Top module: `phy_strap_arbiter`

## Requirements
- R1: While `mgmt_lock` is high, every pin-controlled bit takes its pin-derived value one clock after the pins, and management writes change no bit.
- R2: While `mgmt_lock` is low, pin-derived defaults load into a port's bits only during system reset or that port's stretched reset. After that, pin changes have no effect and writes to register 0 and register 19 of the addressed port set the bits.
- R3: The auto-negotiation restart output of a port pulses for exactly one cycle in two cases. The first is the cycle after a rising edge of `cfg_pin[0]` while the port's auto-negotiation bit (register 0 bit 12) is set. The second is the cycle after an unlocked write of 1 to register 0 bit 9. The pulse is suppressed while the port is held in reset.
- R4: Speed (register 0 bit 13) defaults to `cfg_pin[0]` and link-test disable (register 19 bit 8) defaults to `cfg_pin[1]` when `an_en_pin` is low. When `an_en_pin` is high they default to 1 and 0.
- R5: Fibre mode (register 19 bit 2) defaults to `sigdet_pin[p]` OR (`cfg_pin[2]` AND NOT `an_en_pin`).
- R6: Duplex (register 0 bit 8) defaults to `fdx_fiber_pin` on ports whose fibre default is 1, and to `fdx_pin` on the other ports.
- R7: Register 19 bit 3 defaults to `scr_byp_pin`. `port_scr_bypass` is that bit OR the port's fibre bit.
- R8: Isolate (register 0 bit 10) defaults to `tristate_pin[p]`.
- R9: A port's reset output rises one cycle after `phy_reset_n` is low or its register 0 bit 15 is set, and it stays high for STRETCH cycles after that source is last seen. Bit 15 clears itself when the port reloads its defaults.
- R10: `port_pwrdn[p]` equals `pwrdn_pin` OR register 0 bit 11, with one cycle of latency.
- R11: The address of port p is {`addr_hi_pin`, p}, with the port number in the low two bits.
- R12: A change on `link_up[p]` sets the port's pending flag and drives `irq_n` low on the next cycle. The flag clears only when a read of register 18 directly follows a read of register 1 on the same port. Any other read of that port between the two cancels the sequence, and so does a new change.
- R13: Reads return the following fields. Register 0 holds bit 15 reset, 13 speed, 12 auto-negotiation, 11 power-down, 10 isolate, 9 restart and 8 duplex. Register 1 bit 2 is `link_up`. Register 18 bit 0 is the pending flag. Register 19 holds bit 8 link-test disable, 3 scrambler bypass and 2 fibre. Every other bit reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| mgmt_lock | input | 1 | High: pins own the bits and writes are ignored |
| an_en_pin | input | 1 | Auto-negotiation enable strap |
| cfg_pin | input | 3 | Configuration straps (speed/restart, link test, fibre) |
| fdx_pin | input | 1 | Full-duplex strap for twisted-pair ports |
| fdx_fiber_pin | input | 1 | Full-duplex strap for fibre ports |
| scr_byp_pin | input | 1 | Scrambler bypass strap |
| sigdet_pin | input | NPORTS | Per-port signal detect, forces fibre |
| tristate_pin | input | NPORTS | Per-port isolate strap |
| phy_reset_n | input | 1 | Active-low device reset pin |
| pwrdn_pin | input | 1 | Power-down pin |
| addr_hi_pin | input | ADDR_HI_W | Upper address bits |
| link_up | input | NPORTS | Link status from each port core |
| mg_wr | input | 1 | Register write strobe |
| mg_rd | input | 1 | Register read strobe |
| mg_port | input | 2 | Port selected for access |
| mg_reg | input | 5 | Register index |
| mg_wdata | input | 16 | Write data |
| mg_rdata | output | 16 | Read data, valid the cycle after `mg_rd` |
| port_speed100 | output | NPORTS | Speed bit per port |
| port_fdx | output | NPORTS | Duplex bit per port |
| port_an_en | output | NPORTS | Auto-negotiation enable per port |
| port_an_restart | output | NPORTS | One-cycle restart pulse per port |
| port_fiber | output | NPORTS | Fibre mode per port |
| port_scr_bypass | output | NPORTS | Effective scrambler bypass per port |
| port_link_test_off | output | NPORTS | 10 Mb/s link-test disable per port |
| port_isolate | output | NPORTS | Isolate per port |
| port_reset | output | NPORTS | Stretched reset per port |
| port_pwrdn | output | NPORTS | Power-down per port |
| phy_addr | output | NPORTS*(ADDR_HI_W+2) | Packed per-port addresses, port 0 lowest |
| irq_n | output | 1 | Active-low status-change interrupt |

## Verification
Each kind of wrong internal state shows at the ports, and the timing differs by kind. If a bit has the wrong owner, a pin change or a write reaches the mode outputs when it should not, and this is visible one clock later. If the stretch counter is wrong, `port_reset` falls too early or too late, which shows within STRETCH cycles of the source being released. If the defaults were captured wrongly, a read of register 0 or register 19 returns the bad value on the cycle after the strobe. If the arm flag of the interrupt sequence is stale, `irq_n` clears when it should not (or stays low when it should clear) on the cycle after the register 18 read. This makes the order of the read sequence observable without looking inside the block.

// File: rtl/strap_arb_pkg.sv
package strap_arb_pkg;

  localparam int DW = 16;
  localparam int RIW = 5;

  localparam logic [RIW-1:0] REG_CTRL = 5'd0;
  localparam logic [RIW-1:0] REG_STAT = 5'd1;
  localparam logic [RIW-1:0] REG_IRQ  = 5'd18;
  localparam logic [RIW-1:0] REG_MODE = 5'd19;

  // Per-port register image
  typedef struct packed {
    logic rst_req;
    logic spd100;
    logic an_en;
    logic pd;
    logic iso;
    logic dup;
    logic ltd;
    logic scr;
    logic fiber;
  } port_cfg_t;

  // Global strap inputs
  typedef struct packed {
    logic       an_en;
    logic [2:0] cfg;
    logic       fdx;
    logic       fdx_fiber;
    logic       scr_byp;
  } strap_t;

  function automatic port_cfg_t strap_defaults(strap_t s, logic sd, logic tris);
    port_cfg_t c;
    logic      fib;
    fib       = sd | (~s.an_en & s.cfg[2]);
    c.rst_req = 1'b0;
    c.spd100  = s.an_en | s.cfg[0];
    c.an_en   = s.an_en;
    c.pd      = 1'b0;
    c.iso     = tris;
    c.dup     = fib ? s.fdx_fiber : s.fdx;
    c.ltd     = ~s.an_en & s.cfg[1];
    c.scr     = s.scr_byp;
    c.fiber   = fib;
    return c;
  endfunction

endpackage

// File: rtl/strap_rst_stretch.sv
module strap_rst_stretch #(
  parameter int STRETCH = 5125
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic hold
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOADV = CW'(STRETCH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || raw)
      cnt <= LOADV;
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign hold = (cnt != '0);
endmodule

// File: rtl/strap_port_regs.sv
module strap_port_regs
  import strap_arb_pkg::*;
#(
  parameter int STRETCH = 5125
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock,
  input  strap_t        straps,
  input  logic          sd,
  input  logic          tris,
  input  logic          phy_rst_n,
  input  logic          pd_pin,
  input  logic          cfg0_rise,
  input  logic          wr_ctrl,
  input  logic          wr_mode,
  input  logic [DW-1:0] wdata,
  output port_cfg_t     cfg,
  output logic          restart,
  output logic          hold,
  output logic          pd_out
);
  port_cfg_t dflt;
  logic      raw;
  logic      unused_wbits;

  assign dflt = strap_defaults(straps, sd, tris);
  assign raw  = ~phy_rst_n | cfg.rst_req;
  assign unused_wbits = ^{wdata[14], wdata[7:4], wdata[1:0]};

  strap_rst_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk  (clk),
    .rst  (rst),
    .raw  (raw),
    .hold (hold)
  );

  // Pins win during reset, stretch or lock; otherwise writes own the bits
  always_ff @(posedge clk) begin
    if (rst || hold || lock) begin
      cfg <= dflt;
    end else if (wr_ctrl) begin
      cfg.rst_req <= wdata[15];
      cfg.spd100  <= wdata[13];
      cfg.an_en   <= wdata[12];
      cfg.pd      <= wdata[11];
      cfg.iso     <= wdata[10];
      cfg.dup     <= wdata[8];
    end else if (wr_mode) begin
      cfg.ltd     <= wdata[8];
      cfg.scr     <= wdata[3];
      cfg.fiber   <= wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      restart <= 1'b0;
    else
      restart <= ~hold & ((cfg0_rise & cfg.an_en) | (wr_ctrl & ~lock & wdata[9]));
  end

  always_ff @(posedge clk) begin
    if (rst)
      pd_out <= 1'b0;
    else
      pd_out <= pd_pin | cfg.pd;
  end
endmodule

// File: rtl/strap_irq_track.sv
module strap_irq_track (
  input  logic clk,
  input  logic rst,
  input  logic link,
  input  logic rd_stat,
  input  logic rd_irq,
  input  logic rd_other,
  output logic pending
);
  logic link_q;
  logic armed;

  always_ff @(posedge clk) begin
    link_q <= link;
    if (rst) begin
      pending <= 1'b0;
      armed   <= 1'b0;
    end else if (link != link_q) begin
      pending <= 1'b1;
      armed   <= 1'b0;
    end else if (rd_irq) begin
      if (armed) pending <= 1'b0;
      armed <= 1'b0;
    end else if (rd_stat) begin
      armed <= 1'b1;
    end else if (rd_other) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_strap_arbiter.sv
module phy_strap_arbiter
  import strap_arb_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int ADDR_HI_W = 3,
  parameter int STRETCH   = 5125
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                mgmt_lock,
  input  logic                                an_en_pin,
  input  logic [2:0]                          cfg_pin,
  input  logic                                fdx_pin,
  input  logic                                fdx_fiber_pin,
  input  logic                                scr_byp_pin,
  input  logic [NPORTS-1:0]                   sigdet_pin,
  input  logic [NPORTS-1:0]                   tristate_pin,
  input  logic                                phy_reset_n,
  input  logic                                pwrdn_pin,
  input  logic [ADDR_HI_W-1:0]                addr_hi_pin,
  input  logic [NPORTS-1:0]                   link_up,
  input  logic                                mg_wr,
  input  logic                                mg_rd,
  input  logic [1:0]                          mg_port,
  input  logic [4:0]                          mg_reg,
  input  logic [15:0]                         mg_wdata,
  output logic [15:0]                         mg_rdata,
  output logic [NPORTS-1:0]                   port_speed100,
  output logic [NPORTS-1:0]                   port_fdx,
  output logic [NPORTS-1:0]                   port_an_en,
  output logic [NPORTS-1:0]                   port_an_restart,
  output logic [NPORTS-1:0]                   port_fiber,
  output logic [NPORTS-1:0]                   port_scr_bypass,
  output logic [NPORTS-1:0]                   port_link_test_off,
  output logic [NPORTS-1:0]                   port_isolate,
  output logic [NPORTS-1:0]                   port_reset,
  output logic [NPORTS-1:0]                   port_pwrdn,
  output logic [NPORTS*(ADDR_HI_W+2)-1:0]     phy_addr,
  output logic                                irq_n
);
  localparam int PIDX_W = 2;
  localparam int ADDR_W = ADDR_HI_W + PIDX_W;

  strap_t            straps;
  logic              cfg0_q;
  logic              cfg0_rise;
  logic [NPORTS-1:0] pend_vec;
  logic [DW-1:0]     rd_word [NPORTS];

  assign straps    = {an_en_pin, cfg_pin, fdx_pin, fdx_fiber_pin, scr_byp_pin};
  assign cfg0_rise = cfg_pin[0] & ~cfg0_q;

  always_ff @(posedge clk) begin
    cfg0_q <= cfg_pin[0];
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    port_cfg_t cfg_p;
    logic      sel;
    logic      restart_p;
    logic      hold_p;
    logic      pd_p;
    logic      rd_stat_p;
    logic      rd_irq_p;

    assign sel       = (mg_port == PIDX_W'(p));
    assign rd_stat_p = mg_rd & sel & (mg_reg == REG_STAT);
    assign rd_irq_p  = mg_rd & sel & (mg_reg == REG_IRQ);

    strap_port_regs #(.STRETCH(STRETCH)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .lock      (mgmt_lock),
      .straps    (straps),
      .sd        (sigdet_pin[p]),
      .tris      (tristate_pin[p]),
      .phy_rst_n (phy_reset_n),
      .pd_pin    (pwrdn_pin),
      .cfg0_rise (cfg0_rise),
      .wr_ctrl   (mg_wr & sel & (mg_reg == REG_CTRL)),
      .wr_mode   (mg_wr & sel & (mg_reg == REG_MODE)),
      .wdata     (mg_wdata),
      .cfg       (cfg_p),
      .restart   (restart_p),
      .hold      (hold_p),
      .pd_out    (pd_p)
    );

    strap_irq_track u_irq (
      .clk      (clk),
      .rst      (rst),
      .link     (link_up[p]),
      .rd_stat  (rd_stat_p),
      .rd_irq   (rd_irq_p),
      .rd_other (mg_rd & sel & ~rd_stat_p & ~rd_irq_p),
      .pending  (pend_vec[p])
    );

    assign port_speed100[p]      = cfg_p.spd100;
    assign port_fdx[p]           = cfg_p.dup;
    assign port_an_en[p]         = cfg_p.an_en;
    assign port_an_restart[p]    = restart_p;
    assign port_fiber[p]         = cfg_p.fiber;
    assign port_scr_bypass[p]    = cfg_p.scr | cfg_p.fiber;
    assign port_link_test_off[p] = cfg_p.ltd;
    assign port_isolate[p]       = cfg_p.iso;
    assign port_reset[p]         = hold_p;
    assign port_pwrdn[p]         = pd_p;

    assign rd_word[p] =
      (mg_reg == REG_CTRL) ? {cfg_p.rst_req, 1'b0, cfg_p.spd100, cfg_p.an_en, cfg_p.pd,
                              cfg_p.iso, restart_p, cfg_p.dup, 8'h00} :
      (mg_reg == REG_STAT) ? {13'b0, link_up[p], 2'b0} :
      (mg_reg == REG_IRQ)  ? {15'b0, pend_vec[p]} :
      (mg_reg == REG_MODE) ? {7'b0, cfg_p.ltd, 4'b0, cfg_p.scr, cfg_p.fiber, 2'b0} :
                             16'h0000;

    always_ff @(posedge clk) begin
      phy_addr[p*ADDR_W +: ADDR_W] <= {addr_hi_pin, PIDX_W'(p)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      mg_rdata <= '0;
    else if (mg_rd)
      mg_rdata <= rd_word[mg_port];
  end

  assign irq_n = ~|pend_vec;
endmodule

// File: rtl/phy_strap_arbiter_chk.sv
module phy_strap_arbiter_chk #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mgmt_lock,
  input logic [NPORTS-1:0] tristate_pin,
  input logic [NPORTS-1:0] port_isolate,
  input logic              phy_reset_n,
  input logic [NPORTS-1:0] port_reset,
  input logic              pwrdn_pin,
  input logic [NPORTS-1:0] port_pwrdn,
  input logic [NPORTS-1:0] link_up,
  input logic              irq_n,
  input logic              cfg0,
  input logic              mg_wr,
  input logic [NPORTS-1:0] port_an_en,
  input logic [NPORTS-1:0] port_an_restart
);
  // R1: under lock the isolate bits track the tristate pins one clock later
  p_lock_tracks_pins_r1: assert property (@(posedge clk) disable iff (rst)
    $past(mgmt_lock) |-> (port_isolate == $past(tristate_pin)));

  // R9: reset pin forces every port into reset on the next cycle
  p_pin_reset_r9: assert property (@(posedge clk) disable iff (rst)
    !phy_reset_n |=> (port_reset == {NPORTS{1'b1}}));

  // R10: power-down pin reaches every port after one cycle
  p_pwrdn_pin_r10: assert property (@(posedge clk) disable iff (rst)
    pwrdn_pin |=> (port_pwrdn == {NPORTS{1'b1}}));

  // R12: a link change raises the interrupt on the next cycle
  p_link_event_r12: assert property (@(posedge clk) disable iff (rst)
    (link_up != $past(link_up)) |=> !irq_n);

  // R3: a strap edge restarts exactly the enabled ports not in reset
  p_restart_edge_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(cfg0) && !mg_wr) |=> (port_an_restart == $past(port_an_en & ~port_reset)));
endmodule

bind phy_strap_arbiter phy_strap_arbiter_chk #(.NPORTS(NPORTS)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .mgmt_lock       (mgmt_lock),
  .tristate_pin    (tristate_pin),
  .port_isolate    (port_isolate),
  .phy_reset_n     (phy_reset_n),
  .port_reset      (port_reset),
  .pwrdn_pin       (pwrdn_pin),
  .port_pwrdn      (port_pwrdn),
  .link_up         (link_up),
  .irq_n           (irq_n),
  .cfg0            (cfg_pin[0]),
  .mg_wr           (mg_wr),
  .port_an_en      (port_an_en),
  .port_an_restart (port_an_restart)
);

// File: tb/phy_strap_arbiter_test.sv
module phy_strap_arbiter_test;
  localparam int NP = 4;
  localparam int ST = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        mgmt_lock, an_en_pin, fdx_pin, fdx_fiber_pin, scr_byp_pin;
  logic [2:0]  cfg_pin;
  logic [NP-1:0] sigdet_pin, tristate_pin, link_up;
  logic        phy_reset_n, pwrdn_pin;
  logic [2:0]  addr_hi_pin;
  logic        mg_wr, mg_rd;
  logic [1:0]  mg_port;
  logic [4:0]  mg_reg;
  logic [15:0] mg_wdata, mg_rdata;
  logic [NP-1:0] port_speed100, port_fdx, port_an_en, port_an_restart, port_fiber;
  logic [NP-1:0] port_scr_bypass, port_link_test_off, port_isolate, port_reset, port_pwrdn;
  logic [NP*5-1:0] phy_addr;
  logic        irq_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phy_strap_arbiter #(.NPORTS(NP), .ADDR_HI_W(3), .STRETCH(ST)) uut (.*);

  // [28] an [27:25] cfg [24] fdx [23] fdx_fiber [22] scr [21:18] sigdet [17:14] tristate
  // [13:10] fiber [9:6] duplex [5:2] bypass [1] speed [0] link-test-off
  localparam logic [28:0] VEC [6] = '{
    {1'b0,3'b000,1'b0,1'b0,1'b0,4'b0000,4'b0000, 4'b0000,4'b0000,4'b0000,1'b0,1'b0},
    {1'b0,3'b011,1'b1,1'b0,1'b1,4'b0101,4'b1010, 4'b0101,4'b1010,4'b1111,1'b1,1'b1},
    {1'b0,3'b100,1'b0,1'b1,1'b0,4'b0000,4'b0000, 4'b1111,4'b1111,4'b1111,1'b0,1'b0},
    {1'b1,3'b111,1'b1,1'b0,1'b0,4'b1000,4'b0001, 4'b1000,4'b0111,4'b1000,1'b1,1'b0},
    {1'b1,3'b000,1'b0,1'b1,1'b1,4'b0011,4'b1111, 4'b0011,4'b0011,4'b1111,1'b1,1'b0},
    {1'b0,3'b101,1'b0,1'b0,1'b0,4'b0010,4'b0100, 4'b1111,4'b0000,4'b1111,1'b1,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mwrite(input logic [1:0] p, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    mg_wr = 1'b1; mg_port = p; mg_reg = r; mg_wdata = d;
    @(negedge clk);
    mg_wr = 1'b0;
  endtask

  task automatic mread(input logic [1:0] p, input logic [4:0] r);
    @(negedge clk);
    mg_rd = 1'b1; mg_port = p; mg_reg = r;
    @(negedge clk);
    mg_rd = 1'b0;
  endtask

  initial begin
    rst = 1'b1; mgmt_lock = 1'b0; an_en_pin = 1'b0; cfg_pin = 3'b001;
    fdx_pin = 1'b0; fdx_fiber_pin = 1'b0; scr_byp_pin = 1'b0;
    sigdet_pin = '0; tristate_pin = '0; link_up = '0;
    phy_reset_n = 1'b1; pwrdn_pin = 1'b0; addr_hi_pin = 3'b101;
    mg_wr = 1'b0; mg_rd = 1'b0; mg_port = '0; mg_reg = '0; mg_wdata = '0;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    chk("R9 reset held after release", port_reset, 4'b1111);
    chk("R12 irq idle after reset", irq_n, 1'b1);
    chk("R2 speed default from strap", port_speed100, 4'b1111);
    chk("R10 pwrdn idle", port_pwrdn, 4'b0000);
    chk("R11 port addresses", phy_addr, {5'b10111, 5'b10110, 5'b10101, 5'b10100});
    wait_n(10);
    chk("R9 reset stretch ends", port_reset, 4'b0000);

    // R2: pin change after reset is ignored, writes take over
    cfg_pin = 3'b000;
    wait_n(3);
    chk("R2 pin change ignored", port_speed100, 4'b1111);
    mwrite(2'd2, 5'd0, 16'h0900);
    chk("R2 write sets speed", port_speed100, 4'b1011);
    chk("R2 write sets duplex", port_fdx, 4'b0100);
    wait_n(1);
    chk("R10 pwrdn from register", port_pwrdn, 4'b0100);
    mread(2'd2, 5'd0);
    chk("R13 read control", mg_rdata, 16'h0900);
    pwrdn_pin = 1'b1;
    wait_n(1);
    chk("R10 pwrdn pin all ports", port_pwrdn, 4'b1111);
    pwrdn_pin = 1'b0;
    wait_n(1);
    chk("R10 pwrdn pin released", port_pwrdn, 4'b0100);

    // R7 / R13: mode register
    mwrite(2'd3, 5'd19, 16'h0108);
    mread(2'd3, 5'd19);
    chk("R13 read mode", mg_rdata, 16'h0108);
    chk("R7 bypass from register", port_scr_bypass, 4'b1000);
    chk("R4 link test off written", port_link_test_off, 4'b1000);
    mwrite(2'd3, 5'd19, 16'h0004);
    chk("R7 fibre forces bypass", port_scr_bypass, 4'b1000);
    chk("R5 fibre bit written", port_fiber, 4'b1000);

    // R3: restart by write
    mwrite(2'd1, 5'd0, 16'h1200);
    chk("R3 restart by write", port_an_restart, 4'b0010);
    wait_n(1);
    chk("R3 restart is one cycle", port_an_restart, 4'b0000);

    // R9: register reset of port 0, self-clearing, reloads defaults
    mwrite(2'd0, 5'd0, 16'h8000);
    wait_n(1);
    chk("R9 register reset port 0 only", port_reset, 4'b0001);
    wait_n(12);
    chk("R9 register reset ends", port_reset, 4'b0000);
    chk("R2 defaults re-sampled on port reset", port_speed100, 4'b1000);
    mread(2'd0, 5'd0);
    chk("R9 reset bit self-clears", mg_rdata, 16'h0000);

    // R9: pin reset
    phy_reset_n = 1'b0;
    wait_n(1);
    chk("R9 pin reset all ports", port_reset, 4'b1111);
    phy_reset_n = 1'b1;
    wait_n(12);
    chk("R9 pin reset ends", port_reset, 4'b0000);
    chk("R2 defaults after pin reset", port_speed100, 4'b0000);

    // R1, R4-R8: pin table under lock
    mgmt_lock = 1'b1;
    for (int i = 0; i < 6; i++) begin
      logic [28:0] v;
      v = VEC[i];
      an_en_pin = v[28]; cfg_pin = v[27:25]; fdx_pin = v[24]; fdx_fiber_pin = v[23];
      scr_byp_pin = v[22]; sigdet_pin = v[21:18]; tristate_pin = v[17:14];
      wait_n(2);
      chk($sformatf("R1 R8 isolate vec %0d", i), port_isolate, v[17:14]);
      chk($sformatf("R5 fibre vec %0d", i), port_fiber, v[13:10]);
      chk($sformatf("R6 duplex vec %0d", i), port_fdx, v[9:6]);
      chk($sformatf("R7 bypass vec %0d", i), port_scr_bypass, v[5:2]);
      chk($sformatf("R4 speed vec %0d", i), port_speed100, {4{v[1]}});
      chk($sformatf("R4 link test vec %0d", i), port_link_test_off, {4{v[0]}});
    end
    mwrite(2'd1, 5'd0, 16'h0400);
    wait_n(1);
    chk("R1 write ignored under lock", port_isolate, 4'b0100);

    // R3: strap edge with and without auto-negotiation
    an_en_pin = 1'b1; cfg_pin = 3'b000; sigdet_pin = '0;
    wait_n(2);
    cfg_pin = 3'b001;
    wait_n(1);
    chk("R3 strap edge restarts all", port_an_restart, 4'b1111);
    wait_n(1);
    chk("R3 strap restart pulse ends", port_an_restart, 4'b0000);
    an_en_pin = 1'b0; cfg_pin = 3'b000;
    wait_n(2);
    cfg_pin = 3'b001;
    wait_n(1);
    chk("R3 no restart when disabled", port_an_restart, 4'b0000);
    chk("R4 strap sets speed when disabled", port_speed100, 4'b1111);

    // R12: interrupt clear order
    mgmt_lock = 1'b0;
    link_up = 4'b0010;
    wait_n(1);
    chk("R12 irq on link change", irq_n, 1'b0);
    mread(2'd1, 5'd18);
    chk("R13 pending bit read", mg_rdata, 16'h0001);
    chk("R12 reg18 alone keeps irq", irq_n, 1'b0);
    mread(2'd1, 5'd1);
    chk("R13 link bit read", mg_rdata, 16'h0004);
    mread(2'd1, 5'd0);
    mread(2'd1, 5'd18);
    chk("R12 interposed read cancels", irq_n, 1'b0);
    mread(2'd1, 5'd1);
    mread(2'd1, 5'd18);
    chk("R12 ordered reads clear irq", irq_n, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule